// File: doc/BRIEF.md
# Data-Ready Triggered Three-Channel SPI Sample Reader

This block is an SPI master that reads a continuously converting three-channel 24-bit delta-sigma converter. The converter signals each finished conversion with a short low pulse on an active-low ready line. The reader synchronizes that line and qualifies it. On an accepted falling edge it drops chip select and sends a read command byte. It throws away the byte that arrives while the command is being sent. It then clocks in three big-endian bytes per channel and delivers each channel as a signed 24-bit value with a one-cycle strobe.

Two transfer shapes are supported. In per-channel mode each channel gets its own chip-select window and its own command byte. In burst mode a single window carries one command byte followed by nine data bytes covering channels 0, 1 and 2. A ready pulse arriving while a read is still running does not start a second read; it sets a sticky overrun flag instead. A brief high glitch on the ready line is rejected, because the line must be seen high for a parameterised number of cycles before another falling edge counts.

Top module: `drdy_spi_adc_reader`

## Requirements
- R1: SPI runs with clock polarity 1 and phase 1. `sclk` idles high. `mosi` changes only on `sclk` falling edges and `miso` is sampled on rising edges. Bytes go most significant bit first.
- R2: One `sclk` period inside a byte lasts PRESCALE*(1+RATE) system clocks, split evenly between the low and high halves (the product must be even).
- R3: A read starts only when `drdy_n`, after a two-flop synchronizer, goes low having been high for at least HIGH_QUAL consecutive cycles. Each low pulse starts at most one read. A high glitch shorter than HIGH_QUAL cycles starts no read.
- R4: The first byte in each chip-select window is the command byte (address<<1)|0x41. The address is the channel index 0..2 in per-channel mode and 0 in burst mode. The byte received during the command byte is discarded after it has fully arrived.
- R5: Each sample is three transfers with 0x00 on `mosi`. The received bytes are joined most significant first into a 24-bit two's-complement value, and every byte is assembled in a freshly cleared shift register.
- R6: With `burst_mode`=0 a read uses three chip-select windows, each holding one command byte and three data bytes. Between windows `cs_n` stays high for at least CS_GAP cycles. With `burst_mode`=1 a read uses one window holding one command byte and nine data bytes. The mode is latched when the read starts.
- R7: Each sample is presented with a one-cycle `smp_valid`, `smp_chan` = 0, 1, 2 in that order, `smp_data` as the 24-bit value and `smp_data_ext` as its 32-bit sign extension.
- R8: A qualified trigger that arrives while a read is in progress sets `overrun`, which stays set until reset. The running read completes unchanged and no extra read starts.
- R9: After reset `cs_n`=1, `sclk`=1, `mosi`=0, `smp_valid`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n | input | 1 | Converter ready pulse, active low, asynchronous |
| burst_mode | input | 1 | 1 = one window for all channels, 0 = one window per channel |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to converter |
| cs_n | output | 1 | Chip select, active low |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 2 | Channel index of the presented sample |
| smp_data | output | 24 | Signed 24-bit sample |
| smp_data_ext | output | 32 | Sample sign-extended to 32 bits |
| overrun | output | 1 | Sticky flag: trigger arrived during a read |

## Verification
The bench builds the reader with PRESCALE=2, RATE=1, HIGH_QUAL=4 and CS_GAP=3. With these values an SCLK period is four system clocks and a burst read finishes in about 330 cycles, so the bench can sweep both transfer modes over many reads. Those reads include the full-scale codes 0x800000, 0x7FFFFF and 0xFFFFFF. The short qualification window lets a two-cycle high glitch and a fully qualified overlapping pulse both be placed inside one running read. A converter model in the bench decodes the command byte to choose the channel it returns, so a wrong address or a misaligned dummy byte shows up directly as wrong sample data.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int          NUM_CHAN       = 3;
    localparam int          BYTES_PER_SMP  = 3;
    localparam logic [7:0]  READ_CMD_BASE  = 8'h41;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_CMD_GO,
        RD_CMD_WAIT,
        RD_DAT_GO,
        RD_DAT_WAIT,
        RD_GAP
    } rd_state_e;

    typedef struct packed {
        logic [1:0]  chan;
        logic [23:0] value;
    } sample_t;

    function automatic logic [7:0] read_cmd(input logic [1:0] addr);
        return {5'b0, addr, 1'b0} | READ_CMD_BASE;
    endfunction

    function automatic logic [31:0] sext24(input logic [23:0] v);
        return {{8{v[23]}}, v};
    endfunction

endpackage

// File: rtl/drdy_qualifier.sv
module drdy_qualifier #(
    parameter int HIGH_QUAL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n,
    output logic trig
);
    localparam int CW = $clog2(HIGH_QUAL + 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= 1'b1;
            sync_q   <= 1'b1;
            high_cnt <= '0;
        end else begin
            meta_q <= drdy_n;
            sync_q <= meta_q;
            if (!sync_q)
                high_cnt <= '0;
            else if (high_cnt != CW'(HIGH_QUAL))
                high_cnt <= high_cnt + 1'b1;
        end
    end

    // fire once: low now, and the line was high long enough just before
    assign trig = !sync_q && (high_cnt == CW'(HIGH_QUAL));

    assert_single_trig_R3: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic          run_q;
    logic          sclk_q;
    logic          mosi_q;
    logic [7:0]    tx_sh;
    logic [6:0]    rx_sh;
    logic [2:0]    bit_cnt;
    logic [HW-1:0] half_cnt;
    logic          done_q;
    logic [7:0]    rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            sclk_q   <= 1'b1;
            mosi_q   <= 1'b0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            bit_cnt  <= '0;
            half_cnt <= '0;
            done_q   <= 1'b0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    run_q    <= 1'b1;
                    tx_sh    <= tx_byte;
                    rx_sh    <= '0;          // flush any leftover bits
                    bit_cnt  <= '0;
                    half_cnt <= '0;
                end
            end else if (half_cnt == HW'(HALF - 1)) begin
                half_cnt <= '0;
                if (sclk_q) begin
                    // leading (falling) edge: launch next bit
                    sclk_q <= 1'b0;
                    mosi_q <= tx_sh[7];
                    tx_sh  <= {tx_sh[6:0], 1'b0};
                end else begin
                    // trailing (rising) edge: capture
                    sclk_q <= 1'b1;
                    rx_sh  <= {rx_sh[5:0], miso};
                    if (bit_cnt == 3'd7) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                        rx_q   <= {rx_sh, miso};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = mosi_q;
    assign done    = done_q;
    assign rx_byte = rx_q;

    assert_done_on_high_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> sclk);

endmodule

// File: rtl/drdy_spi_adc_reader.sv
module drdy_spi_adc_reader
    import adcrd_pkg::*;
#(
    parameter int PRESCALE  = 2,
    parameter int RATE      = 4,
    parameter int HIGH_QUAL = 8,
    parameter int CS_GAP    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        drdy_n,
    input  logic        burst_mode,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    output logic        smp_valid,
    output logic [1:0]  smp_chan,
    output logic [23:0] smp_data,
    output logic [31:0] smp_data_ext,
    output logic        overrun
);
    localparam int DIV  = PRESCALE * (1 + RATE);
    localparam int HALF = DIV / 2;
    localparam int GW   = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [1:0] LAST_CHAN = 2'(NUM_CHAN - 1);
    localparam logic [1:0] LAST_BYTE = 2'(BYTES_PER_SMP - 1);

    logic       trig;
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;

    rd_state_e     state;
    logic [1:0]    chan;
    logic [1:0]    bidx;
    logic [15:0]   acc;
    logic          mode_q;
    logic          cs_q;
    logic [GW-1:0] gap_cnt;
    logic          vld_q;
    sample_t       smp_q;
    logic          ovr_q;
    logic [23:0]   acc_next;

    drdy_qualifier #(.HIGH_QUAL(HIGH_QUAL)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .drdy_n (drdy_n),
        .trig   (trig)
    );

    spi_byte_engine #(.HALF(HALF)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    always_comb begin
        eng_start = (state == RD_CMD_GO) || (state == RD_DAT_GO);
        eng_tx    = (state == RD_CMD_GO) ? read_cmd(mode_q ? 2'd0 : chan) : 8'h00;
        acc_next  = {acc, eng_rx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RD_IDLE;
            chan    <= '0;
            bidx    <= '0;
            acc     <= '0;
            mode_q  <= 1'b0;
            cs_q    <= 1'b1;
            gap_cnt <= '0;
            vld_q   <= 1'b0;
            smp_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (trig && state != RD_IDLE)
                ovr_q <= 1'b1;
            unique case (state)
                RD_IDLE: if (trig) begin
                    cs_q   <= 1'b0;
                    chan   <= '0;
                    mode_q <= burst_mode;
                    state  <= RD_CMD_GO;
                end
                RD_CMD_GO:  state <= RD_CMD_WAIT;
                RD_CMD_WAIT: if (eng_done) begin
                    // response to the command byte is dropped here
                    bidx  <= '0;
                    state <= RD_DAT_GO;
                end
                RD_DAT_GO:  state <= RD_DAT_WAIT;
                RD_DAT_WAIT: if (eng_done) begin
                    acc <= acc_next[15:0];
                    if (bidx == LAST_BYTE) begin
                        vld_q       <= 1'b1;
                        smp_q.chan  <= chan;
                        smp_q.value <= acc_next;
                        bidx        <= '0;
                        if (chan == LAST_CHAN) begin
                            cs_q  <= 1'b1;
                            state <= RD_IDLE;
                        end else begin
                            chan <= chan + 1'b1;
                            if (mode_q) begin
                                state <= RD_DAT_GO;
                            end else begin
                                cs_q    <= 1'b1;
                                gap_cnt <= '0;
                                state   <= RD_GAP;
                            end
                        end
                    end else begin
                        bidx  <= bidx + 1'b1;
                        state <= RD_DAT_GO;
                    end
                end
                RD_GAP: begin
                    if (gap_cnt == GW'(CS_GAP - 1)) begin
                        cs_q  <= 1'b0;
                        state <= RD_CMD_GO;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign cs_n         = cs_q;
    assign smp_valid    = vld_q;
    assign smp_chan     = smp_q.chan;
    assign smp_data     = smp_q.value;
    assign smp_data_ext = sext24(smp_q.value);
    assign overrun      = ovr_q;

    assert_mosi_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> $fell(sclk));

    assert_sclk_inside_cs_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> !cs_n);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    assert_chan_range_R7: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (smp_chan != 2'd3));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: tb/drdy_spi_adc_reader_bench.sv
module drdy_spi_adc_reader_bench;
    localparam int PRESCALE  = 2;
    localparam int RATE      = 1;
    localparam int HIGH_QUAL = 4;
    localparam int CS_GAP    = 3;
    localparam int DIV       = PRESCALE * (1 + RATE);
    localparam int HALF      = DIV / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drdy_n = 1'b1;
    logic        burst_mode = 1'b0;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, smp_valid, overrun;
    logic [1:0]  smp_chan;
    logic [23:0] smp_data;
    logic [31:0] smp_data_ext;

    always #5 clk = ~clk;

    drdy_spi_adc_reader #(
        .PRESCALE(PRESCALE), .RATE(RATE), .HIGH_QUAL(HIGH_QUAL), .CS_GAP(CS_GAP)
    ) u_drdy_spi_adc_reader (
        .clk(clk), .rst(rst), .drdy_n(drdy_n), .burst_mode(burst_mode),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
        .smp_data_ext(smp_data_ext), .overrun(overrun)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] sval(input int ev, input int ch);
        if (ev == 0) return (ch == 0) ? 24'h800000 : (ch == 1) ? 24'h7FFFFF : 24'hFFFFFF;
        if (ev == 1) return (ch == 0) ? 24'h000000 : (ch == 1) ? 24'h000001 : 24'h800001;
        return 24'((ev * 32'h003A5C71) + (ch * 32'h009E3779) + 32'h55);
    endfunction

    // converter model state
    int       cur_ev = 0;
    bit       cur_burst = 0;
    int       cs_in_ev = 0;
    int       sbyte = 0;
    int       sbit = 0;
    int       s_addr = 0;
    logic [7:0] rxsh = '0;
    time      t_rise = 0;
    time      t_fall = 0;
    time      t_cs_up = 0;
    int       sclk_err = 0;
    int       mosi_err = 0;
    int       gap_err = 0;
    int       got_cnt = 0;
    int       got_base = 0;

    function automatic logic resp_bit();
        logic [7:0]  b;
        logic [23:0] v;
        int d, ch;
        if (sbyte == 0) begin
            b = 8'hEE;                       // garbage during the command byte
        end else begin
            d  = sbyte - 1;
            ch = s_addr + d / 3;
            if (ch > 2) b = 8'h00;
            else begin
                v = sval(cur_ev, ch);
                b = 8'(v >> (8 * (2 - d % 3)));
            end
        end
        return b[7 - sbit];
    endfunction

    always @(negedge cs_n) begin
        if (cs_in_ev > 0 && ($time - t_cs_up) < CS_GAP * 10) gap_err++;
        sbyte = 0;
        sbit  = 0;
        cs_in_ev++;
    end

    always @(posedge cs_n) t_cs_up = $time;

    always @(negedge sclk) if (!cs_n) begin
        miso   <= resp_bit();
        t_fall = $time;
    end

    always @(posedge sclk) if (!cs_n) begin
        logic [7:0] exp_cmd;
        if (sbit > 0 && ($time - t_rise) != DIV * 10) sclk_err++;
        if (($time - t_fall) != HALF * 10) sclk_err++;
        t_rise = $time;
        rxsh = {rxsh[6:0], mosi};
        sbit++;
        if (sbit == 8) begin
            if (sbyte == 0) begin
                exp_cmd = cur_burst ? 8'h41 : (8'h41 | 8'((cs_in_ev - 1) << 1));
                chk(rxsh == exp_cmd, "R4 command byte", rxsh, exp_cmd);
                s_addr = (rxsh >> 1) & 3;
            end else if (rxsh != 8'h00) begin
                mosi_err++;
            end
            sbyte++;
            sbit = 0;
        end
    end

    // output monitor and launch-edge check, sampled away from the active edge
    logic prev_mosi = 1'b0;
    logic prev_sclk = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n && mosi !== prev_mosi && !(prev_sclk && !sclk)) mosi_err++;
            if (smp_valid) begin
                int idx;
                logic [23:0] ev;
                idx = got_cnt - got_base;
                if (idx > 2) begin
                    chk(1'b0, "R8 extra sample", idx, 2);
                end else begin
                    ev = sval(cur_ev, idx);
                    chk(smp_chan == 2'(idx), "R7 channel order", smp_chan, idx);
                    chk(smp_data == ev, "R5 sample value", smp_data, ev);
                    chk(smp_data_ext == {{8{ev[23]}}, ev}, "R7 sign extension",
                        smp_data_ext, {{8{ev[23]}}, ev});
                end
                got_cnt++;
            end
        end
        prev_mosi = mosi;
        prev_sclk = sclk;
    end

    task automatic run_event(input int ev, input bit burst, input bit glitch,
                             input bit overlap, input bit exp_ovr);
        cur_ev    = ev;
        cur_burst = burst;
        burst_mode = burst;
        cs_in_ev  = 0;
        got_base  = got_cnt;
        sclk_err  = 0;
        mosi_err  = 0;
        gap_err   = 0;
        drdy_n = 1'b0;
        repeat (8) @(negedge clk);
        drdy_n = 1'b1;
        if (glitch) begin
            repeat (2) @(negedge clk);
            drdy_n = 1'b0;            // slow-edge bounce: high too briefly
            repeat (5) @(negedge clk);
            drdy_n = 1'b1;
        end
        if (overlap) begin
            repeat (20) @(negedge clk);
            drdy_n = 1'b0;            // clean second pulse during the read
            repeat (8) @(negedge clk);
            drdy_n = 1'b1;
        end
        for (int i = 0; i < 3000 && (got_cnt - got_base) < 3; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk((got_cnt - got_base) == 3, "R3 one read per pulse", got_cnt - got_base, 3);
        chk(cs_in_ev == (burst ? 1 : 3), "R6 chip-select windows", cs_in_ev, burst ? 1 : 3);
        chk(gap_err == 0, "R6 deselect gap", gap_err, 0);
        chk(sclk_err == 0, "R2 sclk timing", sclk_err, 0);
        chk(mosi_err == 0, "R1 mosi launch and zero fill", mosi_err, 0);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 idle levels", {cs_n, sclk}, 2'b11);
        chk(overrun == exp_ovr, "R8 overrun flag", overrun, exp_ovr);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9 reset cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R9 reset sclk", sclk, 1);
        chk(mosi == 1'b0, "R9 reset mosi", mosi, 0);
        chk(smp_valid == 1'b0, "R9 reset valid", smp_valid, 0);
        chk(overrun == 1'b0, "R9 reset overrun", overrun, 0);
        repeat (20) @(negedge clk);
        for (int ev = 0; ev < 10; ev++)
            run_event(ev, bit'(ev % 2), (ev == 4) || (ev == 5), 1'b0, 1'b0);
        run_event(10, 1'b1, 1'b0, 1'b1, 1'b1);   // R8 overlap in burst
        run_event(11, 1'b0, 1'b0, 1'b0, 1'b1);   // R8 flag stays, reads continue
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule